// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level radix table from a word-addressed memory. Pages are 4 KB. Each table fills exactly one page and holds 1024 four-byte entries. A virtual address therefore splits into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset (bits 11:0).

A context register holds the frame number of the root table. Software reloads it on a context switch through a load strobe, and the block takes that strobe only while it is idle. A walk starts when a request arrives while the walker is idle. The walker then issues one memory read per level and waits for each response before it moves on. It ends with a one-cycle done pulse that carries the translated address, or a one-cycle fault pulse that reports the level that stopped it.

Every table entry has the same format:
- bit 0 is valid.
- bit 1 is writable.
- bits 31:12 hold the next-table frame at the first level and the page frame at the leaf.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to word address {root frame, va[31:22]}, that is, root + index1×4 in bytes.
- R2: If the first-level entry is valid, the second read goes to word address {entry[31:12], va[21:12]}.
- R3: A successful walk raises `done` for exactly one cycle, with `physAddr` = {leaf entry[31:12], va[11:0]}.
- R4: A first-level entry with bit 0 clear ends the walk with `fault` and `faultLevel` = 0, and no second read is issued.
- R5: A leaf entry with bit 0 clear ends the walk with `fault` and `faultLevel` = 1.
- R6: A write request (`reqWrite` = 1) whose leaf entry has bit 1 clear faults with `faultLevel` = 1, while a read request to the same leaf completes.
- R7: `busy` is high from the cycle after a request is accepted through the done or fault cycle. A request presented while `busy` is high is ignored and causes no extra read.
- R8: `rootWe` loads `rootData` into the root register only while the walker is idle. A load while busy has no effect on any later walk.
- R9: `memReqValid` stays high, with `memWordAddr` stable, until `memRspValid` arrives, and only one read is outstanding at a time.
- R10: `done` and `fault` are never high together, and `busy` is low in the cycle after either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWe | input | 1 | Load strobe for the root frame register |
| rootData | input | 20 | Frame number of the root table |
| reqValid | input | 1 | Start a walk (taken only when idle) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Memory read request, held until response |
| memWordAddr | output | 30 | Word address of the entry to read |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation ready |
| fault | output | 1 | One-cycle pulse: walk stopped |
| faultLevel | output | 1 | Level that faulted (0 = first, 1 = leaf) |
| physAddr | output | 32 | Translated physical address, valid with done |

## Verification
A wrong state register shows up within one memory round trip:
- A skipped level shows up as a missing read, or as a read at the wrong word address.
- A walk that does not stop on an invalid first-level entry issues a spurious second read.
- A lost response latch gives a bad frame in `physAddr` in the done cycle.

The bench logs every read address the memory sees and checks the count and the values after each walk. It also varies the memory latency, so that an early or repeated advance changes the number of reads. A root register that accepts a load while busy only shows up on the next walk's first address, so the bench checks that next walk.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int PFN_W = VA_W - OFF_W;
  localparam int WA_W  = PFN_W + IDX_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic latchReq;
    logic latchNext;
    logic latchLeaf;
    logic loadRoot;
    logic selLeaf;
  } walkStrobe_t;
endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int ADDR_W = VA_W,
  parameter int OFFS_W = OFF_W,
  parameter int IDXW   = IDX_W,
  localparam int FRAME_W = ADDR_W - OFFS_W,
  localparam int WORD_W  = FRAME_W + IDXW
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [FRAME_W-1:0] rootData,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic [WORD_W-1:0]  memWordAddr,
  output logic               entryValid,
  output logic               entryWritable,
  output logic               isWrite,
  output logic [ADDR_W-1:0]  physAddr
);
  logic [FRAME_W-1:0] rootFrame;
  logic [FRAME_W-1:0] nextFrame;
  logic [FRAME_W-1:0] leafFrame;
  logic [ADDR_W-1:0]  vaReg;
  logic               writeReg;

  wire [IDXW-1:0]   idxTop  = vaReg[ADDR_W-1 -: IDXW];
  wire [IDXW-1:0]   idxLeaf = vaReg[OFFS_W+IDXW-1 -: IDXW];
  wire [OFFS_W-1:0] pgOff   = vaReg[OFFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootFrame <= '0;
      nextFrame <= '0;
      leafFrame <= '0;
      vaReg     <= '0;
      writeReg  <= 1'b0;
    end else begin
      if (strobe.loadRoot) rootFrame <= rootData;
      if (strobe.latchReq) begin
        vaReg    <= reqVaddr;
        writeReg <= reqWrite;
      end
      if (strobe.latchNext) nextFrame <= memRspData[ADDR_W-1:OFFS_W];
      if (strobe.latchLeaf) leafFrame <= memRspData[ADDR_W-1:OFFS_W];
    end
  end

  always_comb begin
    if (strobe.selLeaf) memWordAddr = {nextFrame, idxLeaf};
    else                memWordAddr = {rootFrame, idxTop};
  end

  assign entryValid    = memRspData[0];
  assign entryWritable = memRspData[1];
  assign isWrite       = writeReg;
  assign physAddr      = {leafFrame, pgOff};
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rootWe,
  input  logic        memRspValid,
  input  logic        entryValid,
  input  logic        entryWritable,
  input  logic        isWrite,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        done,
  output logic        fault,
  output logic        faultLevel
);
  walkState_t state, stateNext;
  logic       levelReg, levelNext;

  always_comb begin
    stateNext = state;
    levelNext = levelReg;
    strobe    = '0;
    strobe.selLeaf = (state == ST_RD2);
    unique case (state)
      ST_IDLE: begin
        strobe.loadRoot = rootWe;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext = ST_RD1;
        end
      end
      ST_RD1: if (memRspValid) begin
        if (entryValid) begin
          strobe.latchNext = 1'b1;
          stateNext = ST_RD2;
        end else begin
          levelNext = 1'b0;
          stateNext = ST_FAULT;
        end
      end
      ST_RD2: if (memRspValid) begin
        if (!entryValid || (isWrite && !entryWritable)) begin
          levelNext = 1'b1;
          stateNext = ST_FAULT;
        end else begin
          strobe.latchLeaf = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      levelReg <= 1'b0;
    end else begin
      state    <= stateNext;
      levelReg <= levelNext;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_RD1) || (state == ST_RD2);
  assign done        = (state == ST_DONE);
  assign fault       = (state == ST_FAULT);
  assign faultLevel  = levelReg;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rootWe,
  input  logic [PFN_W-1:0] rootData,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  output logic             busy,
  output logic             memReqValid,
  output logic [WA_W-1:0]  memWordAddr,
  input  logic             memRspValid,
  input  logic [VA_W-1:0]  memRspData,
  output logic             done,
  output logic             fault,
  output logic             faultLevel,
  output logic [VA_W-1:0]  physAddr
);
  walkStrobe_t strobe;
  logic entryValid, entryWritable, isWrite;

  walk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rootWe(rootWe),
    .memRspValid(memRspValid), .entryValid(entryValid),
    .entryWritable(entryWritable), .isWrite(isWrite), .strobe(strobe),
    .busy(busy), .memReqValid(memReqValid), .done(done), .fault(fault),
    .faultLevel(faultLevel)
  );

  walk_dpath #(.ADDR_W(VA_W), .OFFS_W(OFF_W), .IDXW(IDX_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rootData(rootData),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .memRspData(memRspData),
    .memWordAddr(memWordAddr), .entryValid(entryValid),
    .entryWritable(entryWritable), .isWrite(isWrite), .physAddr(physAddr)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import walk_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            memReqValid,
  input logic [WA_W-1:0] memWordAddr,
  input logic            memRspValid,
  input logic            done,
  input logic            fault
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |=> !done && !fault && !busy); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> memReqValid && $stable(memWordAddr)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid); // R7
  AST_OUTCOME_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> busy && !memReqValid); // R7
endmodule

bind pt_walker pt_walker_chk uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReqValid(memReqValid),
  .memWordAddr(memWordAddr), .memRspValid(memRspValid),
  .done(done), .fault(fault)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootWe = 1'b0;
  logic [19:0] rootData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        busy, memReqValid, done, fault, faultLevel;
  logic [29:0] memWordAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [31:0] physAddr;

  int testCount = 0;
  int failCount = 0;
  int memLat = 0;
  int rdCount = 0;
  logic [29:0] rdAddr [4];
  logic [31:0] mem [logic [29:0]];

  logic        gotDone, gotFault, gotLevel;
  logic [31:0] gotPhys;

  pt_walker uut (.*);

  always #10 clk = ~clk;

  initial begin : memModel
    int waitCnt;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memRspValid) begin
        memRspValid = 1'b0;
      end else if (memReqValid) begin
        if (waitCnt >= memLat) begin
          memRspData = mem.exists(memWordAddr) ? mem[memWordAddr] : 32'h0;
          memRspValid = 1'b1;
          if (rdCount < 4) rdAddr[rdCount] = memWordAddr;
          rdCount++;
          waitCnt = 0;
        end else waitCnt++;
      end
    end
  end

  function automatic logic [31:0] mkEnt(logic [19:0] frame, logic w, logic v);
    return {frame, 10'd0, w, v};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(logic [31:0] va, logic wr);
    rdCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    gotDone = 0; gotFault = 0;
    for (int i = 0; i < 200; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    gotDone = done; gotFault = fault; gotLevel = faultLevel; gotPhys = physAddr;
    check("R10 exclusive", {31'd0, done && fault}, 32'd0);
    @(negedge clk);
    check("R10 pulse", {30'd0, done, fault}, 32'd0);
    check("R10 idle after", {31'd0, busy}, 32'd0);
  endtask

  task automatic loadRoot(logic [19:0] r);
    @(negedge clk);
    rootWe = 1'b1; rootData = r;
    @(negedge clk);
    rootWe = 1'b0;
  endtask

  task automatic testReset();
    check("R7 reset busy", {31'd0, busy}, 32'd0);
    check("R9 reset memReq", {31'd0, memReqValid}, 32'd0);
    check("R10 reset outcome", {30'd0, done, fault}, 32'd0);
  endtask

  task automatic testReadOk();
    logic [31:0] va;
    va = {10'h003, 10'h155, 12'hABC};
    walk(va, 1'b0);
    check("R1 first read", {2'b0, rdAddr[0]}, {2'b0, 20'h00010, 10'h003});
    check("R2 second read", {2'b0, rdAddr[1]}, {2'b0, 20'h00200, 10'h155});
    check("R3 done", {31'd0, gotDone}, 32'd1);
    check("R3 physAddr", gotPhys, {20'hBEEF1, 12'hABC});
    check("R6 read on readonly ok", {31'd0, gotFault}, 32'd0);
  endtask

  task automatic testWriteOk();
    walk({10'h003, 10'h156, 12'h004}, 1'b1);
    check("R6 write writable done", {31'd0, gotDone}, 32'd1);
    check("R3 write phys", gotPhys, {20'h0C0DE, 12'h004});
  endtask

  task automatic testWriteDenied();
    walk({10'h003, 10'h155, 12'h010}, 1'b1);
    check("R6 write readonly fault", {31'd0, gotFault}, 32'd1);
    check("R6 fault level", {31'd0, gotLevel}, 32'd1);
  endtask

  task automatic testL1Invalid();
    walk({10'h3FF, 10'h001, 12'h000}, 1'b0);
    check("R4 fault", {31'd0, gotFault}, 32'd1);
    check("R4 level", {31'd0, gotLevel}, 32'd0);
    check("R4 single read", rdCount, 1);
  endtask

  task automatic testL2Invalid();
    walk({10'h003, 10'h157, 12'h000}, 1'b0);
    check("R5 fault", {31'd0, gotFault}, 32'd1);
    check("R5 level", {31'd0, gotLevel}, 32'd1);
    check("R5 two reads", rdCount, 2);
  endtask

  task automatic testBusyIgnore();
    memLat = 2;
    rdCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {10'h003, 10'h156, 12'h020}; reqWrite = 1'b0;
    @(negedge clk);
    reqVaddr = {10'h3FF, 10'h000, 12'h000};
    check("R7 busy after accept", {31'd0, busy}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    check("R7 first walk done", {31'd0, done}, 32'd1);
    check("R7 phys of first", physAddr, {20'h0C0DE, 12'h020});
    @(negedge clk);
    repeat (4) @(negedge clk);
    check("R7 no extra reads", rdCount, 2);
    memLat = 0;
  endtask

  task automatic testRootLoad();
    memLat = 1;
    rdCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {10'h003, 10'h155, 12'h001}; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    rootWe = 1'b1; rootData = 20'h00077;
    @(negedge clk);
    rootWe = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    @(negedge clk);
    memLat = 0;
    walk({10'h003, 10'h155, 12'h002}, 1'b0);
    check("R8 busy load ignored", {2'b0, rdAddr[0]}, {2'b0, 20'h00010, 10'h003});
    loadRoot(20'h00040);
    walk({10'h003, 10'h155, 12'h002}, 1'b0);
    check("R8 idle load used", {2'b0, rdAddr[0]}, {2'b0, 20'h00040, 10'h003});
    check("R3 alt root phys", gotPhys, {20'h12345, 12'h002});
    loadRoot(20'h00010);
  endtask

  task automatic testSlowMem();
    memLat = 5;
    walk({10'h003, 10'h155, 12'h7FF}, 1'b0);
    check("R9 slow reads", rdCount, 2);
    check("R9 slow second addr", {2'b0, rdAddr[1]}, {2'b0, 20'h00200, 10'h155});
    check("R9 slow phys", gotPhys, {20'hBEEF1, 12'h7FF});
    memLat = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : mainSeq
    mem[{20'h00010, 10'h003}] = mkEnt(20'h00200, 1'b0, 1'b1);
    mem[{20'h00200, 10'h155}] = mkEnt(20'hBEEF1, 1'b0, 1'b1);
    mem[{20'h00200, 10'h156}] = mkEnt(20'h0C0DE, 1'b1, 1'b1);
    mem[{20'h00200, 10'h157}] = mkEnt(20'hDEAD0, 1'b1, 1'b0);
    mem[{20'h00010, 10'h3FF}] = mkEnt(20'h00300, 1'b1, 1'b0);
    mem[{20'h00040, 10'h003}] = mkEnt(20'h00500, 1'b1, 1'b1);
    mem[{20'h00500, 10'h155}] = mkEnt(20'h12345, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadRoot(20'h00010);
    testReadOk();
    testWriteOk();
    testWriteDenied();
    testL1Invalid();
    testL2Invalid();
    testBusyIgnore();
    testRootLoad();
    testSlowMem();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule